// File: doc/BRIEF.md
# Dual-Channel Packed SPI Readout Formatter

This block sits on the slave side of an SPI link. It builds the 32-bit word that a frame shifts out on SDO. There are two layouts. The regular layout returns a 16-bit register value. The packed layout returns two measurement channels at once, each cut to 12 bits, for faster multi-axis readout. A 3-bit data-type input chooses between them. The choice is made when each frame begins, so while the field is nonzero every frame is packed, whether the master is reading or writing.

Each layout has a 4-bit status header and ends in a 4-bit CRC. In the header, the top bit is the OR of every error flag. The other three bits are one group of the status vector. The group is chosen by a command field that the slave received on SDI in the previous frame.

The SPI pins are sampled on the system clock through two-stage synchronisers. The SPI register file and the measurement engine are outside the block. They appear only as input vectors.

Top module: `dpk_sdo_formatter`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_sdo_oe` is 0 and `spi_sdo` is 0. While chip select is low, `spi_sdo_oe` is 1.
- R2: The 32-bit frame is latched when chip select falls. Bit 31 appears on SDO first. Each SCK falling edge moves SDO on to the next lower bit, and the master samples on SCK rising edges.
- R3: When `data_type` is 0 at frame start, the frame is {err_summary, group[2:0], 8'h00, reg_rdata[15:0], crc[3:0]}.
- R4: When `data_type` is nonzero at frame start, the frame is {err_summary, group[2:0], chan_a[15:4], chan_b[15:4], crc[3:0]}.
- R5: The layout is chosen anew for every frame. Frames stay packed for as long as `data_type` is nonzero, and return to the regular layout once it is 0.
- R6: Frame bit 31 is the OR of all `err_flags` bits at frame start.
- R7: Frame bits [30:28] hold `stat_flags[3k+2:3k]`, where k is a 2-bit command. The command is taken from bits [5:4] of the previous frame's SDI word (the first bit received is bit 31) when chip select rises. After reset, k is 0.
- R8: Frame bits [3:0] are a CRC over frame bits [31:4], taken MSB first. The polynomial is x^4+x+1 and the seed is 4'hF.
- R9: Both channels are sampled in the same cycle as the frame latch. Changes to `chan_a` or `chan_b` during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sdi | input | 1 | SPI data from master |
| spi_sdo | output | 1 | SPI data to master |
| spi_sdo_oe | output | 1 | Output enable for SDO pad; 0 means high impedance |
| data_type | input | 3 | Layout select; nonzero selects the packed two-channel frame |
| chan_a | input | 16 | First channel result |
| chan_b | input | 16 | Second channel result |
| reg_rdata | input | 16 | Register value for the regular frame |
| stat_flags | input | 12 | Four 3-bit status groups |
| err_flags | input | 8 | Error flags folded into the summary bit |

## Verification
A change on an SPI pin reaches the block's registers on the third system clock edge after it occurs: two synchroniser stages, then one edge-detect register. So the frame latch, the SDO output enable and each SDO bit settle within three clocks of the matching CS or SCK edge. The bench holds every SPI level for ten clocks and samples SDO at the end of that hold, just before it raises SCK, which leaves seven clocks of margin. The command captured when chip select rises is visible only in the next frame. The bench therefore keeps its own copy of the last command it sent and uses it to predict the status group.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  localparam int FRAME_W  = 32;
  localparam int CRC_W    = 4;
  localparam int HDR_W    = 4;
  localparam int GRP_BITS = HDR_W - 1;

  typedef enum logic {
    FMT_REGULAR = 1'b0,
    FMT_PACKED  = 1'b1
  } fmt_e;

  typedef struct packed {
    logic                err_any;
    logic [GRP_BITS-1:0] grp;
  } hdr_t;
endpackage

// File: rtl/dpk_in_sync.sv
module dpk_in_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] stg_q, stg_d;
  logic [N-1:0]             prev_q;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/dpk_crc_chain.sv
module dpk_crc_chain #(
  parameter int               DATA_W = 28,
  parameter int               CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY   = 4'h3,
  parameter logic [CRC_W-1:0] SEED   = 4'hF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] st [DATA_W+1];

  assign st[0] = SEED;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb        = st[i][CRC_W-1] ^ data_i[DATA_W-1-i];
    assign st[i+1]   = {st[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  assign crc_o = st[DATA_W];
endmodule

// File: rtl/dpk_frame_build.sv
module dpk_frame_build
  import dpk_pkg::*;
#(
  parameter int CH_W   = 16,
  parameter int PK_W   = 12,
  parameter int REG_W  = 16,
  parameter int N_GRP  = 4,
  parameter int ERR_W  = 8,
  localparam int CMD_W  = $clog2(N_GRP),
  localparam int STAT_W = N_GRP * GRP_BITS
) (
  input  fmt_e                fmt_i,
  input  logic [CH_W-1:0]     chan_a_i,
  input  logic [CH_W-1:0]     chan_b_i,
  input  logic [REG_W-1:0]    reg_rdata_i,
  input  logic [STAT_W-1:0]   stat_i,
  input  logic [ERR_W-1:0]    err_i,
  input  logic [CMD_W-1:0]    cmd_i,
  output logic [FRAME_W-1:0]  frame_o
);
  localparam int BODY_W = FRAME_W - CRC_W;
  localparam int PAD_W  = BODY_W - HDR_W - REG_W;

  logic [GRP_BITS-1:0] grp_arr [N_GRP];
  hdr_t                hdr;
  logic [BODY_W-1:0]   body;
  logic [CRC_W-1:0]    crc;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_arr[g] = stat_i[g*GRP_BITS +: GRP_BITS];
  end

  always_comb begin
    hdr.err_any = |err_i;
    hdr.grp     = grp_arr[cmd_i];
    if (fmt_i == FMT_PACKED) begin
      body = {hdr, chan_a_i[CH_W-1 -: PK_W], chan_b_i[CH_W-1 -: PK_W]};
    end else begin
      body = {hdr, {PAD_W{1'b0}}, reg_rdata_i};
    end
  end

  dpk_crc_chain #(
    .DATA_W(BODY_W),
    .CRC_W (CRC_W),
    .POLY  (4'h3),
    .SEED  (4'hF)
  ) u_crc (
    .data_i(body),
    .crc_o (crc)
  );

  assign frame_o = {body, crc};
endmodule

// File: rtl/dpk_sdo_shift.sv
module dpk_sdo_shift
  import dpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_low_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [FRAME_W-1:0] rx_o
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic               oe_q, oe_d;
  logic               tx_en, rx_en;

  always_comb begin
    oe_d  = oe_q;
    if (cs_fall_i) oe_d = 1'b1;
    else if (cs_rise_i) oe_d = 1'b0;

    tx_en = cs_fall_i | (sck_fall_i & oe_q);
    tx_d  = cs_fall_i ? frame_i : {tx_q[FRAME_W-2:0], 1'b0};

    rx_en = cs_fall_i | (sck_rise_i & cs_low_i);
    rx_d  = cs_fall_i ? '0 : {rx_q[FRAME_W-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      oe_q <= oe_d;
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign sdo_o    = tx_q[FRAME_W-1] & oe_q;
  assign sdo_oe_o = oe_q;
  assign rx_o     = rx_q;

  a_r2_latch_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i |=> (tx_q == $past(frame_i)));
  a_r2_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall_i && oe_q && !cs_fall_i) |=> (tx_q[FRAME_W-1:1] == $past(tx_q[FRAME_W-2:0])));
  a_r1_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i |=> sdo_oe_o);
  a_r1_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> !sdo_oe_o);
endmodule

// File: rtl/dpk_sdo_formatter.sv
module dpk_sdo_formatter
  import dpk_pkg::*;
#(
  parameter int CH_W   = 16,
  parameter int PK_W   = 12,
  parameter int REG_W  = 16,
  parameter int N_GRP  = 4,
  parameter int ERR_W  = 8,
  parameter int DT_W   = 3,
  parameter int CMD_LSB = 4,
  localparam int CMD_W  = $clog2(N_GRP),
  localparam int STAT_W = N_GRP * GRP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic [DT_W-1:0]   data_type,
  input  logic [CH_W-1:0]   chan_a,
  input  logic [CH_W-1:0]   chan_b,
  input  logic [REG_W-1:0]  reg_rdata,
  input  logic [STAT_W-1:0] stat_flags,
  input  logic [ERR_W-1:0]  err_flags
);
  localparam int PIN_CS  = 0;
  localparam int PIN_SCK = 1;
  localparam int PIN_SDI = 2;

  logic [2:0]         lvl, rise, fall;
  logic [FRAME_W-1:0] frame, rx_word;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  fmt_e               fmt_sel;

  dpk_in_sync #(.N(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({spi_sdi, spi_sck, spi_cs_n}),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    fmt_sel = (data_type != '0) ? FMT_PACKED : FMT_REGULAR;
    cmd_d   = rise[PIN_CS] ? rx_word[CMD_LSB +: CMD_W] : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  dpk_frame_build #(
    .CH_W(CH_W), .PK_W(PK_W), .REG_W(REG_W), .N_GRP(N_GRP), .ERR_W(ERR_W)
  ) u_build (
    .fmt_i      (fmt_sel),
    .chan_a_i   (chan_a),
    .chan_b_i   (chan_b),
    .reg_rdata_i(reg_rdata),
    .stat_i     (stat_flags),
    .err_i      (err_flags),
    .cmd_i      (cmd_q),
    .frame_o    (frame)
  );

  dpk_sdo_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_low_i  (~lvl[PIN_CS]),
    .cs_fall_i (fall[PIN_CS]),
    .cs_rise_i (rise[PIN_CS]),
    .sck_rise_i(rise[PIN_SCK]),
    .sck_fall_i(fall[PIN_SCK]),
    .sdi_i     (lvl[PIN_SDI]),
    .frame_i   (frame),
    .sdo_o     (spi_sdo),
    .sdo_oe_o  (spi_sdo_oe),
    .rx_o      (rx_word)
  );

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[PIN_CS] |=> $stable(cmd_q));
  a_r7_cmd_take: assert property (@(posedge clk) disable iff (!rst_n)
    rise[PIN_CS] |=> (cmd_q == $past(rx_word[CMD_LSB +: CMD_W])));
endmodule

// File: tb/dpk_sdo_formatter_tb.sv
`timescale 1ns/1ps
module dpk_sdo_formatter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic spi_sck, spi_cs_n, spi_sdi;
  logic spi_sdo, spi_sdo_oe;
  logic [2:0]  data_type;
  logic [15:0] chan_a, chan_b, reg_rdata;
  logic [11:0] stat_flags;
  logic [7:0]  err_flags;

  int checks = 0;
  int errors = 0;
  logic [1:0] cmd_m;

  always #2.5 clk = ~clk;

  dpk_sdo_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .data_type(data_type), .chan_a(chan_a), .chan_b(chan_b),
    .reg_rdata(reg_rdata), .stat_flags(stat_flags), .err_flags(err_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc4(input logic [27:0] d);
    logic [3:0] c = 4'hF;
    for (int i = 27; i >= 0; i--) begin
      logic fb = c[3] ^ d[i];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'h3;
    end
    return c;
  endfunction

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
    logic [3:0]  hdr;
    logic [27:0] body;
    hdr = {|err_flags, stat_flags[cmd_m*3 +: 3]};
    if (data_type != 3'd0) body = {hdr, a[15:4], b[15:4]};
    else                   body = {hdr, 8'h00, reg_rdata};
    return {body, crc4(body)};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One full frame; optionally changes the channels after bit 20 leaves.
  task automatic xfer(input logic [31:0] mosi, input bit mid_chg, output logic [31:0] miso);
    spi_cs_n = 1'b0;
    wait_clk(10);
    chk("R1 oe high in frame", {31'd0, spi_sdo_oe}, 32'd1);
    for (int i = 31; i >= 0; i--) begin
      miso[i] = spi_sdo;
      spi_sdi = mosi[i];
      if (mid_chg && i == 20) begin
        chan_a = ~chan_a;
        chan_b = ~chan_b;
      end
      wait_clk(5);
      spi_sck = 1'b1;
      wait_clk(10);
      spi_sck = 1'b0;
      wait_clk(10);
    end
    spi_cs_n = 1'b1;
    wait_clk(10);
    chk("R1 idle after frame", {30'd0, spi_sdo_oe, spi_sdo}, 32'd0);
    cmd_m = mosi[5:4];
  endtask

  task automatic t_reset;
    chk("R1 reset state", {30'd0, spi_sdo_oe, spi_sdo}, 32'd0);
  endtask

  task automatic t_regular;
    logic [31:0] exp, got;
    data_type = 3'd0; reg_rdata = 16'hBEEF; stat_flags = 12'hA5C; err_flags = 8'h00;
    exp = model(chan_a, chan_b);
    spi_cs_n = 1'b0;
    wait_clk(10);
    chk("R2 first bit on SDO", {31'd0, spi_sdo}, {31'd0, exp[31]});
    spi_cs_n = 1'b1;
    wait_clk(10);
    xfer(32'h0000_0020, 1'b0, got);
    chk("R3 regular frame", got, exp);
    chk("R7 reset group 0", {29'd0, got[30:28]}, {29'd0, 3'b100});
    chk("R8 crc regular", {28'd0, got[3:0]}, {28'd0, crc4(exp[31:4])});
  endtask

  task automatic t_packed;
    logic [31:0] exp, got;
    data_type = 3'd5; chan_a = 16'h1234; chan_b = 16'hFEDC;
    exp = model(chan_a, chan_b);
    xfer(32'h8000_0010, 1'b0, got);
    chk("R4 packed frame", got, exp);
    chk("R7 group from prior cmd 2", {29'd0, got[30:28]}, {29'd0, stat_flags[8:6]});
  endtask

  task automatic t_persist;
    logic [31:0] exp, got;
    exp = model(chan_a, chan_b);
    xfer(32'h0000_0030, 1'b0, got);
    chk("R5 packed persists", got, exp);
    data_type = 3'd1; chan_a = 16'hFFFF; chan_b = 16'hFFFF;
    exp = model(chan_a, chan_b);
    xfer(32'h0000_0000, 1'b0, got);
    chk("R8 crc all ones channels", got, exp);
    chk("R7 group 3", {29'd0, got[30:28]}, {29'd0, stat_flags[11:9]});
  endtask

  task automatic t_err;
    logic [31:0] got;
    err_flags = 8'h40;
    xfer(32'h0, 1'b0, got);
    chk("R6 summary set", {31'd0, got[31]}, 32'd1);
    err_flags = 8'h00;
    xfer(32'h0, 1'b0, got);
    chk("R6 summary clear", {31'd0, got[31]}, 32'd0);
  endtask

  task automatic t_snapshot;
    logic [31:0] exp, got;
    chan_a = 16'hA0B1; chan_b = 16'h3C4D;
    exp = model(chan_a, chan_b);
    xfer(32'h0, 1'b1, got);
    chk("R9 channels snapshot", got, exp);
  endtask

  task automatic t_back;
    logic [31:0] exp, got;
    data_type = 3'd0; reg_rdata = 16'h0F1E;
    exp = model(chan_a, chan_b);
    xfer(32'h0, 1'b0, got);
    chk("R5 back to regular", got, exp);
  endtask

  initial begin
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_sdi = 1'b0;
    data_type = '0; chan_a = '0; chan_b = '0; reg_rdata = '0;
    stat_flags = '0; err_flags = '0; cmd_m = 2'd0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_regular();
    t_packed();
    t_persist();
    t_err();
    t_snapshot();
    t_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule